// File: doc/BRIEF.md
# DAC Sample Source Controller

This block chooses, for each DAC channel on its own, what the converter is fed: samples streamed from a DMA engine, or a fixed programmable value. A small state machine per channel passes streamed samples through while streaming is allowed. It parks the output on the channel's programmed value when software asks for a direct constant, or when a cyclic stream is suspended. On request it drains whatever is still queued upstream by accepting and discarding it, so software never has to empty the FIFO by hand.

The suspend flag and the flush enable are shared by all channels. The constant value and its enable belong to each channel. Samples leave the block through a register, with a valid bit per channel.

Top module: `dac_stream_ctrl`

## Requirements
- R1: A synchronous active-high reset puts every channel in the idle state: dac_data is 0, dac_valid is 0 and dma_ready is 0.
- R2: An idle channel with dma_valid high, suspend low and raw_en low enters streaming at the next edge. While streaming, every sample accepted (dma_valid and dma_ready both high at an edge) appears on that channel's dac_data with dac_valid high right after that edge. After an edge with no accepted sample, dac_valid is 0.
- R3: dma_ready is high only in two cases: while streaming with suspend and raw_en both low, or while flushing. It is 0 in the very cycle that suspend or raw_en rises during streaming, so no sample is taken at the switch.
- R4: If suspend (or raw_en) rises during streaming while flush_en is low, the channel goes to hold. In hold, dac_data shows the channel's raw_value with dac_valid high, and dma_ready stays 0, so queued data is left untouched.
- R5: If suspend (or raw_en) rises during streaming while flush_en is high, the channel goes to flush. In flush, dma_ready is 1 and accepted samples are thrown away, never shown on dac_data; the output shows raw_value with dac_valid high. The channel moves to hold at the edge where dma_valid or flush_en is low.
- R6: An idle channel with raw_en high goes to hold with no DMA activity. Its dac_data shows raw_value with dac_valid high from the second edge on.
- R7: A channel in hold with flush_en and dma_valid both high goes to flush, even when hold was entered through raw_en.
- R8: A channel in hold returns to idle when raw_en and suspend are both low (and no flush starts). In idle, dac_data is 0 and dac_valid is 0 one edge later.
- R9: Channels are independent. Each channel's raw_value and raw_en affect only that channel, and a channel's dma_valid does not move another channel's state.
- R10: In hold, a change of raw_value shows on dac_data after one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_data | input | NUM_CH*DATA_W | Streamed samples; channel c in bits [c*DATA_W +: DATA_W] |
| dma_valid | input | NUM_CH | Sample present, per channel |
| dma_ready | output | NUM_CH | Sample taken, per channel |
| suspend | input | 1 | Stop streaming on all channels |
| flush_en | input | 1 | Allow draining of upstream data |
| raw_value | input | NUM_CH*DATA_W | Fixed value per channel, same packing as dma_data |
| raw_en | input | NUM_CH | Output the fixed value, per channel |
| dac_data | output | NUM_CH*DATA_W | Registered samples to the DAC |
| dac_valid | output | NUM_CH | Registered valid per channel |

## Verification
The bench first checks that dma_ready drops in the same cycle suspend rises. A design that kept ready high there would swallow one sample that appears nowhere. During a flush it checks that the discarded sample never reaches dac_data, which a design passing data through in flush would show. It checks that hold without flush leaves dma_ready low, since a design that drained anyway would lose the cyclic buffer. It also drives raw-mode entry, flush from hold, the return to idle, and distinct constants on both channels at once, to catch a state that leaks between channels or a missed exit from hold.

// File: rtl/dac_stream_pkg.sv
package dac_stream_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_FLUSH  = 2'd2,
        ST_HOLD   = 2'd3
    } ch_state_e;
endpackage

// File: rtl/dac_ch_fsm.sv
module dac_ch_fsm
    import dac_stream_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      src_valid,
    input  logic      suspend,
    input  logic      flush_en,
    input  logic      raw_en,
    output ch_state_e state_q,
    output logic      src_ready
);
    typedef struct packed {
        ch_state_e state;
    } fsm_t;

    fsm_t r_d, r_q;
    logic stop_req;

    always_comb begin
        r_d      = r_q;
        stop_req = suspend || raw_en;
        unique case (r_q.state)
            ST_IDLE: begin
                if (raw_en)
                    r_d.state = ST_HOLD;
                else if (src_valid && !suspend)
                    r_d.state = ST_STREAM;
            end
            ST_STREAM: begin
                if (stop_req)
                    r_d.state = flush_en ? ST_FLUSH : ST_HOLD;
            end
            ST_FLUSH: begin
                if (!src_valid || !flush_en)
                    r_d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (flush_en && src_valid)
                    r_d.state = ST_FLUSH;
                else if (!raw_en && !suspend)
                    r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: ST_IDLE};
        else     r_q <= r_d;
    end

    assign state_q   = r_q.state;
    assign src_ready = (r_q.state == ST_FLUSH) ||
                       ((r_q.state == ST_STREAM) && !suspend && !raw_en);

    p_suspend_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STREAM && suspend && !flush_en) |=> state_q == ST_HOLD);

    p_flush_enter_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STREAM && suspend && flush_en) |=> state_q == ST_FLUSH);

    p_flush_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLUSH && !src_valid) |=> state_q == ST_HOLD);

    p_raw_flush_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && flush_en && src_valid) |=> state_q == ST_FLUSH);

    p_hold_no_ready_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |-> !src_ready);
endmodule

// File: rtl/dac_ch_out.sv
module dac_ch_out
    import dac_stream_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_state_e         state_q,
    input  logic              src_valid,
    input  logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    input  logic [DATA_W-1:0] raw_value,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        unique case (state_q)
            ST_IDLE: begin
                o_d.data  = '0;
                o_d.valid = 1'b0;
            end
            ST_STREAM: begin
                if (src_valid && src_ready) begin
                    o_d.data  = src_data;
                    o_d.valid = 1'b1;
                end else begin
                    o_d.valid = 1'b0;
                end
            end
            default: begin
                o_d.data  = raw_value;
                o_d.valid = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign dac_data  = o_q.data;
    assign dac_valid = o_q.valid;

    p_stream_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STREAM && src_valid && src_ready)
        |=> (dac_valid && dac_data == $past(src_data)));

    p_raw_out_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD || state_q == ST_FLUSH)
        |=> (dac_valid && dac_data == $past(raw_value)));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> (!dac_valid && dac_data == '0));
endmodule

// File: rtl/dac_stream_ctrl.sv
module dac_stream_ctrl
    import dac_stream_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH*DATA_W-1:0] dma_data,
    input  logic [NUM_CH-1:0]        dma_valid,
    output logic [NUM_CH-1:0]        dma_ready,
    input  logic                     suspend,
    input  logic                     flush_en,
    input  logic [NUM_CH*DATA_W-1:0] raw_value,
    input  logic [NUM_CH-1:0]        raw_en,
    output logic [NUM_CH*DATA_W-1:0] dac_data,
    output logic [NUM_CH-1:0]        dac_valid
);
    localparam int BUS_W = NUM_CH * DATA_W;

    logic [BUS_W-1:0] unused_chk;
    assign unused_chk = dma_data ^ raw_value;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_state_e st;
        logic      rdy;

        dac_ch_fsm u_fsm (
            .clk      (clk),
            .rst      (rst),
            .src_valid(dma_valid[c]),
            .suspend  (suspend),
            .flush_en (flush_en),
            .raw_en   (raw_en[c]),
            .state_q  (st),
            .src_ready(rdy)
        );

        dac_ch_out #(.DATA_W(DATA_W)) u_out (
            .clk      (clk),
            .rst      (rst),
            .state_q  (st),
            .src_valid(dma_valid[c]),
            .src_ready(rdy),
            .src_data (dma_data[c*DATA_W +: DATA_W]),
            .raw_value(raw_value[c*DATA_W +: DATA_W]),
            .dac_data (dac_data[c*DATA_W +: DATA_W]),
            .dac_valid(dac_valid[c])
        );

        assign dma_ready[c] = rdy;
    end
endmodule

// File: tb/dac_stream_ctrl_bench.sv
module dac_stream_ctrl_bench;
    localparam int NUM_CH = 2;
    localparam int DATA_W = 16;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [NUM_CH*DATA_W-1:0] dma_data = '0;
    logic [NUM_CH-1:0]        dma_valid = '0;
    logic [NUM_CH-1:0]        dma_ready;
    logic                     suspend = 1'b0;
    logic                     flush_en = 1'b0;
    logic [NUM_CH*DATA_W-1:0] raw_value = '0;
    logic [NUM_CH-1:0]        raw_en = '0;
    logic [NUM_CH*DATA_W-1:0] dac_data;
    logic [NUM_CH-1:0]        dac_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dac_stream_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dac_stream_ctrl (
        .clk(clk), .rst(rst), .dma_data(dma_data), .dma_valid(dma_valid),
        .dma_ready(dma_ready), .suspend(suspend), .flush_en(flush_en),
        .raw_value(raw_value), .raw_en(raw_en), .dac_data(dac_data),
        .dac_valid(dac_valid)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] dout(input int c);
        return dac_data[c*DATA_W +: DATA_W];
    endfunction

    task automatic chk_out(input int c, input logic v, input logic [DATA_W-1:0] d, input string req);
        chk(dac_valid[c] == v, req, {31'd0, dac_valid[c]}, {31'd0, v});
        if (v || d == '0)
            chk(dout(c) == d, req, {16'd0, dout(c)}, {16'd0, d});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk(dac_valid == '0, "R1", {30'd0, dac_valid}, 0);
        chk(dac_data == '0, "R1", dac_data, 0);
        chk(dma_ready == '0, "R1", {30'd0, dma_ready}, 0);
        rst = 1'b0;
        step();
    endtask

    task automatic t_stream();
        dma_valid[0] = 1'b1; dma_data[15:0] = 16'hA001;
        step();
        chk(dma_ready[0] == 1'b1, "R3 ready in stream", {31'd0, dma_ready[0]}, 1);
        chk(dma_ready[1] == 1'b0, "R9 ch1 idle", {31'd0, dma_ready[1]}, 0);
        step();
        chk_out(0, 1'b1, 16'hA001, "R2 first sample");
        dma_data[15:0] = 16'hB002;
        step();
        chk_out(0, 1'b1, 16'hB002, "R2 second sample");
        chk_out(1, 1'b0, 16'h0000, "R9 ch1 quiet");
        dma_valid[0] = 1'b0;
        step();
        chk(dac_valid[0] == 1'b0, "R2 gap", {31'd0, dac_valid[0]}, 0);
    endtask

    task automatic t_suspend_hold();
        raw_value[15:0] = 16'h1234;
        dma_valid[0] = 1'b1; dma_data[15:0] = 16'hC003;
        suspend = 1'b1;
        #0;
        chk(dma_ready[0] == 1'b0, "R3 ready drops with suspend", {31'd0, dma_ready[0]}, 0);
        step();
        chk(dac_valid[0] == 1'b0, "R3 nothing taken at switch", {31'd0, dac_valid[0]}, 0);
        step();
        chk_out(0, 1'b1, 16'h1234, "R4 hold shows raw");
        chk(dma_ready[0] == 1'b0, "R4 hold leaves fifo", {31'd0, dma_ready[0]}, 0);
        raw_value[15:0] = 16'h5678;
        step();
        chk_out(0, 1'b1, 16'h5678, "R10 raw update");
        suspend = 1'b0; dma_valid[0] = 1'b0;
        step();
        step();
        chk_out(0, 1'b0, 16'h0000, "R8 back to idle");
    endtask

    task automatic t_flush();
        raw_value[15:0] = 16'h0F0F;
        dma_valid[0] = 1'b1; dma_data[15:0] = 16'hD004;
        step();
        step();
        chk_out(0, 1'b1, 16'hD004, "R2 restart stream");
        suspend = 1'b1; flush_en = 1'b1; dma_data[15:0] = 16'hE005;
        step();
        chk(dma_ready[0] == 1'b1, "R5 flush ready", {31'd0, dma_ready[0]}, 1);
        step();
        chk_out(0, 1'b1, 16'h0F0F, "R5 discarded not shown");
        dma_valid[0] = 1'b0;
        step();
        step();
        chk(dma_ready[0] == 1'b0, "R5 hold after drain", {31'd0, dma_ready[0]}, 0);
        chk_out(0, 1'b1, 16'h0F0F, "R5 raw after drain");
        suspend = 1'b0; flush_en = 1'b0;
        step();
        step();
        chk_out(0, 1'b0, 16'h0000, "R8 idle after flush");
    endtask

    task automatic t_raw_direct();
        raw_value[31:16] = 16'h2468; raw_en[1] = 1'b1;
        step();
        step();
        chk_out(1, 1'b1, 16'h2468, "R6 direct raw");
        chk_out(0, 1'b0, 16'h0000, "R9 ch0 unaffected");
        chk(dma_ready[1] == 1'b0, "R6 no dma", {31'd0, dma_ready[1]}, 0);
    endtask

    task automatic t_raw_flush();
        flush_en = 1'b1; dma_valid[1] = 1'b1; dma_data[31:16] = 16'h9999;
        step();
        chk(dma_ready[1] == 1'b1, "R7 flush from raw", {31'd0, dma_ready[1]}, 1);
        step();
        chk_out(1, 1'b1, 16'h2468, "R7 raw during flush");
        dma_valid[1] = 1'b0;
        step();
        chk(dma_ready[1] == 1'b0, "R7 back to hold", {31'd0, dma_ready[1]}, 0);
        raw_en[1] = 1'b0; flush_en = 1'b0;
        step();
        step();
        chk_out(1, 1'b0, 16'h0000, "R8 ch1 idle");
    endtask

    task automatic t_two_raw();
        raw_value = {16'hBEEF, 16'h0DAD};
        raw_en = 2'b11;
        step();
        step();
        chk_out(0, 1'b1, 16'h0DAD, "R9 ch0 own raw");
        chk_out(1, 1'b1, 16'hBEEF, "R9 ch1 own raw");
        raw_value[31:16] = 16'h7777;
        step();
        chk_out(1, 1'b1, 16'h7777, "R10 ch1 update");
        chk_out(0, 1'b1, 16'h0DAD, "R9 ch0 steady");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_stream();
        t_suspend_hold();
        t_flush();
        t_raw_direct();
        t_raw_flush();
        t_two_raw();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule